// File: doc/BRIEF.md
# Parallel Prefix Adder

A purely combinational adder that sums two unsigned operands and a carry input. The carry input takes the place of an extra column below bit 0, with generate set to the carry input and propagate held at zero. Each operand column forms its own generate (both bits set) and propagate (either bit set). A prefix network then widens the span each node covers by a factor of two per level. After log2(WIDTH) levels, every column holds the group generate from just below itself down to the carry-input column, and that value is the carry into the column.

Each sum bit is the column's half-sum XOR its carry. The carry output comes from one more combine cell, which merges the top column's generate and propagate with the carry into that column. Nodes whose span already reaches the carry-input column pass their value through unchanged. Nodes that are about to reach it compute only a generate. Full generate/propagate cells appear only where both halves of the span are still open.

Top module: `pfx_adder`

## Requirements
- R1: For every input, {cout_o, sum_o} equals the unsigned (WIDTH+1)-bit value a_i + b_i + cin_i.
- R2: The carry input acts as the column below bit 0. With a_i = b_i = 0, cin_i = 1 gives sum_o = 1 and cout_o = 0, and cin_i = 0 gives all zeros.
- R3: When every column propagates (a_i ^ b_i all ones, a_i & b_i zero), sum_o is all ones and cout_o = 0 for cin_i = 0, and sum_o = 0 and cout_o = 1 for cin_i = 1.
- R4: A generate in column 0 (a_i = 1, b_i all ones) travels through every column above it: cout_o = 1 for both values of cin_i, and sum_o equals cin_i.
- R5: Bit i of sum_o ^ a_i ^ b_i, which is the carry into column i, equals c_i. Here c_0 = cin_i and c_{i+1} = (a_i & b_i) | ((a_i | b_i) & c_i).
- R6: A column with a_i[k] = b_i[k] = 0 kills the carry. The carry into column k+1 is 0 whatever the lower columns and cin_i hold.
- R7: cout_o = (a_i[W-1] & b_i[W-1]) | ((a_i[W-1] | b_i[W-1]) & c_{W-1}), where W is WIDTH.
- R8: With a_i and b_i both all ones and cin_i = 1, sum_o is all ones and cout_o = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into the lowest column |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top column |

## Verification
Two things can meet in one evaluation: the carry input entering the lowest column, and a generate from column 0 that has to travel across every propagating column to the carry output. Both may target the same carry path, so the bench drives patterns that provoke them together. Examples are b_i = ~a_i with cin_i = 1, and a_i = 1 with b_i all ones and cin_i = 1. Random vectors are weighted toward all-propagate operands and operands with a single break in the propagate chain. Each result is judged against the full-width arithmetic sum and against a bit-by-bit ripple model of the carries, which is read back as sum_o ^ a_i ^ b_i.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  // number of span-doubling levels needed to cover n nodes
  function automatic int levels_for(int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/pfx_col_gp.sv
module pfx_col_gp #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] g_o,
  output logic [WIDTH-1:0] p_o,
  output logic [WIDTH-1:0] x_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_col
    assign g_o[i] = a_i[i] & b_i[i];
    assign p_o[i] = a_i[i] | b_i[i];
    assign x_o[i] = a_i[i] ^ b_i[i];
  end
endmodule

// File: rtl/pfx_black_cell.sv
module pfx_black_cell (
  input  logic hi_g_i,
  input  logic hi_p_i,
  input  logic lo_g_i,
  input  logic lo_p_i,
  output logic g_o,
  output logic p_o
);
  assign g_o = hi_g_i | (hi_p_i & lo_g_i);
  assign p_o = hi_p_i & lo_p_i;
endmodule

// File: rtl/pfx_gray_cell.sv
module pfx_gray_cell (
  input  logic hi_g_i,
  input  logic hi_p_i,
  input  logic lo_g_i,
  output logic g_o
);
  // lower half already ends at the carry-in column: only generate is needed
  assign g_o = hi_g_i | (hi_p_i & lo_g_i);
endmodule

// File: rtl/pfx_tree.sv
module pfx_tree
  import pfx_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0] g_i,      // node 0 is the carry-in column
  input  logic [N-1:1] p_i,      // node 0 never propagates
  output logic [N-1:0] grp_g_o   // group generate of node k down to node 0
);
  localparam int LEVELS = levels_for(N);

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
    localparam int D = 1 << lv;
    logic [N-1:0] g_in;
    logic [N-1:0] g_l;
    logic [N-1:D] p_in;

    if (lv == 0) begin : g_src
      assign g_in = g_i;
      assign p_in = p_i;
    end else begin : g_src
      assign g_in = g_lvl[lv-1].g_l;
      assign p_in = g_lvl[lv-1].g_pblk.p_l;
    end

    for (genvar k = 0; k < N && k < 2*D; k++) begin : g_node
      if (k < D) begin : g_pass
        assign g_l[k] = g_in[k];
      end else begin : g_gray
        pfx_gray_cell u_cell (
          .hi_g_i(g_in[k]),
          .hi_p_i(p_in[k]),
          .lo_g_i(g_in[k-D]),
          .g_o   (g_l[k])
        );
      end
    end

    if (2*D < N) begin : g_pblk
      logic [N-1:2*D] p_l;
      for (genvar k = 2*D; k < N; k++) begin : g_node
        pfx_black_cell u_cell (
          .hi_g_i(g_in[k]),
          .hi_p_i(p_in[k]),
          .lo_g_i(g_in[k-D]),
          .lo_p_i(p_in[k-D]),
          .g_o   (g_l[k]),
          .p_o   (p_l[k])
        );
      end
    end
  end

  assign grp_g_o = g_lvl[LEVELS-1].g_l;
endmodule

// File: rtl/pfx_adder.sv
module pfx_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH-1:0] col_g;
  logic [WIDTH-1:0] col_p;
  logic [WIDTH-1:0] col_x;
  logic [WIDTH-1:0] leaf_g;
  logic [WIDTH-1:1] leaf_p;
  logic [WIDTH-1:0] carry;

  pfx_col_gp #(.WIDTH(WIDTH)) u_col (
    .a_i(a_i),
    .b_i(b_i),
    .g_o(col_g),
    .p_o(col_p),
    .x_o(col_x)
  );

  // node k holds column k-1; node 0 is the carry-in column
  assign leaf_g = {col_g[WIDTH-2:0], cin_i};
  assign leaf_p = col_p[WIDTH-2:0];

  pfx_tree #(.N(WIDTH)) u_tree (
    .g_i    (leaf_g),
    .p_i    (leaf_p),
    .grp_g_o(carry)
  );

  assign sum_o = col_x ^ carry;

  pfx_gray_cell u_cout (
    .hi_g_i(col_g[WIDTH-1]),
    .hi_p_i(col_p[WIDTH-1]),
    .lo_g_i(carry[WIDTH-1]),
    .g_o   (cout_o)
  );
endmodule

// File: rtl/pfx_adder_chk.sv
module pfx_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic [WIDTH-1:0] carry_i
);
  always_comb begin
    a_r1_total: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
      else $error("R1 total mismatch");
    a_r2_cin_column: assert (carry_i[0] == cin_i)
      else $error("R2 carry-in column");
    a_r3_all_prop: assert (!(((a_i ^ b_i) == '1) && ((a_i & b_i) == '0))
                           || (sum_o == {WIDTH{~cin_i}} && cout_o == cin_i))
      else $error("R3 all-propagate");
    a_r7_cout: assert (cout_o == ((a_i[WIDTH-1] & b_i[WIDTH-1])
                       | ((a_i[WIDTH-1] | b_i[WIDTH-1]) & carry_i[WIDTH-1])))
      else $error("R7 carry out");
    for (int i = 1; i < WIDTH; i++) begin
      a_r5_ripple: assert (carry_i[i] == ((a_i[i-1] & b_i[i-1])
                           | ((a_i[i-1] | b_i[i-1]) & carry_i[i-1])))
        else $error("R5 carry recurrence at %0d", i);
      a_r6_kill: assert (a_i[i-1] || b_i[i-1] || !carry_i[i])
        else $error("R6 kill at %0d", i);
    end
  end
endmodule

bind pfx_adder pfx_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .cin_i  (cin_i),
  .sum_o  (sum_o),
  .cout_o (cout_o),
  .carry_i(carry)
);

// File: tb/pfx_adder_tb.sv
module pfx_adder_tb;
  localparam int WIDTH           = 16;
  localparam int CLK_PERIOD      = 10;
  localparam int N_RAND          = 4000;
  localparam int WATCHDOG_CYCLES = 100000;
  localparam logic [WIDTH-1:0] ONES = '1;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [WIDTH-1:0] a = '0;
  logic [WIDTH-1:0] b = '0;
  logic             cin = 1'b0;
  logic [WIDTH-1:0] sum;
  logic             cout;
  int               n_chk = 0;
  int               n_err = 0;
  bit               done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfx_adder #(.WIDTH(WIDTH)) u_dut (
    .a_i   (a),
    .b_i   (b),
    .cin_i (cin),
    .sum_o (sum),
    .cout_o(cout)
  );

  function automatic logic [WIDTH:0] ref_total(logic [WIDTH-1:0] x, logic [WIDTH-1:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, c};
  endfunction

  function automatic logic [WIDTH-1:0] ref_carry(logic [WIDTH-1:0] x, logic [WIDTH-1:0] y, logic c);
    logic [WIDTH-1:0] v;
    logic             r;
    r = c;
    for (int i = 0; i < WIDTH; i++) begin
      v[i] = r;
      r = (x[i] & y[i]) | ((x[i] | y[i]) & r);
    end
    return v;
  endfunction

  task automatic check(string req, logic [WIDTH:0] act, logic [WIDTH:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h (a=%h b=%h cin=%b)", req, act, exp, a, b, cin);
    end
  endtask

  task automatic apply(logic [WIDTH-1:0] x, logic [WIDTH-1:0] y, logic c);
    @(posedge clk);
    a = x; b = y; cin = c;
    @(negedge clk);
  endtask

  // generic checks for R1, R5, R7 on the vector currently applied
  task automatic check_all();
    logic [WIDTH-1:0] cv;
    cv = ref_carry(a, b, cin);
    check("R1", {cout, sum}, ref_total(a, b, cin));
    check("R5", {1'b0, sum ^ a ^ b}, {1'b0, cv});
    check("R7", {{WIDTH{1'b0}}, cout},
          {{WIDTH{1'b0}}, (a[WIDTH-1] & b[WIDTH-1]) | ((a[WIDTH-1] | b[WIDTH-1]) & cv[WIDTH-1])});
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [WIDTH-1:0] ra, rb;
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // R2: idle state and carry-in as lowest column
    apply('0, '0, 1'b0);
    check("R2", {cout, sum}, '0);
    apply('0, '0, 1'b1);
    check("R2", {cout, sum}, {1'b0, {(WIDTH-1){1'b0}}, 1'b1});
    check_all();

    // R3: every column propagates
    apply(16'hA5C3, ~16'hA5C3, 1'b0);
    check("R3", {cout, sum}, {1'b0, ONES});
    apply(16'hA5C3, ~16'hA5C3, 1'b1);
    check("R3", {cout, sum}, '0 | {1'b1, {WIDTH{1'b0}}});
    check_all();

    // R4: generate in column 0 runs to the top, with and without carry-in
    apply({{(WIDTH-1){1'b0}}, 1'b1}, ONES, 1'b0);
    check("R4", {cout, sum}, {1'b1, {WIDTH{1'b0}}});
    apply({{(WIDTH-1){1'b0}}, 1'b1}, ONES, 1'b1);
    check("R4", {cout, sum}, {1'b1, {(WIDTH-1){1'b0}}, 1'b1});
    check_all();

    // R6: column 8 kills the carry coming from generating low columns
    apply(16'hFEFF, 16'h00FF, 1'b1);
    check("R6", {{WIDTH{1'b0}}, (sum[9] ^ a[9] ^ b[9])}, '0);
    check_all();

    // R8: maximum operands
    apply(ONES, ONES, 1'b1);
    check("R8", {cout, sum}, {1'b1, ONES});
    check_all();

    // random, weighted toward long propagate chains (R1, R5, R7)
    for (int n = 0; n < N_RAND; n++) begin
      ra = WIDTH'($urandom);
      case ($urandom % 4)
        0: rb = WIDTH'($urandom);
        1: rb = ~ra;
        2: rb = ~ra ^ (WIDTH'(1) << ($urandom % WIDTH));
        default: rb = ra;
      endcase
      apply(ra, rb, 1'($urandom));
      check_all();
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule